// File: doc/BRIEF.md
# Four-Way Inter-Processor Mailbox Register Bank

This block is the shared register bank through which four processors signal one another. Every processor has its own 32-bit register port. Through that port it reaches one 4 KiB window per peer in a local space, where it reads what that peer sent it, and one window per peer in a remote space, where it writes into that peer's receive slot. Each ordered pair of processors has a slot of eight 32-bit information words. Words 0 to 6 carry a 28-byte payload and word 7 is kept for an acknowledge value.

To send, a processor fills the slot through the remote window of the receiver and then writes the doorbell register there. Doorbell bit 6 means "data ready" and bit 7 means "transmit acknowledged". Either bit latches a pending bit for the sender in the receiver's status register. The receiver enables sources in its mask register and clears pending bits with write-one-to-clear. Its interrupt line is the registered OR of the enabled pending bits.

Top module: `mbx_bank`

## Requirements
- R1: The address of a port is {space, window, offset}. Bit 14 selects the remote space (1) or the local space (0), bits 13:12 name the peer window, and bits 11:0 are the offset. The offsets are status 0x00, clear 0x04, mask 0x0C, doorbell 0x10, and information word k at 0x14 + 4k for k from 0 to 7. Status, clear and mask are reached in the local space through any window.
- R2: A remote-space write by processor s to information word k of window r stores word k of slot (receiver r, sender s). Processor r reads and writes that word in its local space, window s. A remote-space read by s returns the same word. All eight words of a slot are stored independently.
- R3: The pending bit for peer q in the status of owner p is q when q < p and q-1 otherwise, so the three peers use bits 0, 1 and 2 in ascending channel order.
- R4: A remote-space doorbell write from s to window r with bit 6 or bit 7 set sets status bit (R3 mapping) of r on the next clock edge. Doorbell writes with neither bit set leave status unchanged. Status otherwise holds until cleared.
- R5: Writing the clear register clears every status bit whose data bit is 1. Bits above the peer range are ignored, so 0xFF clears all.
- R6: When a doorbell and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The mask register (bits 2:0, 1 = enabled) reads back as written. The interrupt output equals the OR over bits of status AND mask, registered, so it changes one cycle after the status or mask change. With mask 0 the interrupt stays low.
- R8: The doorbell register reads as 0. Unused offsets read as 0 and writes to them have no effect. Information or doorbell accesses to a processor's own window index are ignored and read 0.
- R9: Reset clears every status, mask and information word and drives every interrupt low.
- R10: If a remote write by the sender and a local write by the receiver hit the same information word in one cycle, the sender's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 4 | Per-processor access strobe |
| bus_write | input | 4 | Per-processor write (1) or read (0) |
| bus_addr | input | 60 | Per-processor 15-bit address, processor p at bits 15p+14:15p |
| bus_wdata | input | 128 | Per-processor write data, processor p at bits 32p+31:32p |
| bus_rdata | output | 128 | Per-processor read data, combinational from registered state |
| irq | output | 4 | Per-processor interrupt line |

## Verification
A write takes effect at the clock edge that ends its cycle. A read returns registered state within the same cycle, so a value written is seen by a read in the following cycle. A status bit is visible at the first sampling point after the doorbell edge, while the interrupt follows only at the next one. The bench drives on falling edges and samples one nanosecond later or at the next falling edge. It checks that the interrupt is still low one sample after a doorbell and high one sample after that, and the same two-step timing when it falls after a clear. The same-cycle contention cases are driven on two ports in a single cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Register offsets inside a 4 KiB window
  localparam int OFF_STATUS    = 'h000;
  localparam int OFF_CLEAR     = 'h004;
  localparam int OFF_MASK      = 'h00C;
  localparam int OFF_DOOR      = 'h010;
  localparam int OFF_INFO_BASE = 'h014;

  // Doorbell request bits
  localparam int DOOR_DATA_BIT = 6;
  localparam int DOOR_ACK_BIT  = 7;

  typedef struct packed {
    logic info;
    logic status;
    logic clear;
    logic mask;
    logic door;
  } mbx_hit_t;

  // Pending-bit index of a peer, skipping the owner
  function automatic int peer_bit(input int owner, input int peer);
    return (peer < owner) ? peer : peer - 1;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NPROC      = 4,
  parameter int WIN_SHIFT  = 12,
  parameter int INFO_WORDS = 8,
  parameter int WSELW      = (NPROC > 1) ? $clog2(NPROC) : 1,
  parameter int IDXW       = (INFO_WORDS > 1) ? $clog2(INFO_WORDS) : 1,
  parameter int AW         = WIN_SHIFT + WSELW + 1
) (
  input  logic [AW-1:0]    addr_i,
  output mbx_hit_t         hit_o,
  output logic             remote_o,
  output logic [WSELW-1:0] win_o,
  output logic [IDXW-1:0]  idx_o
);

  localparam logic [WIN_SHIFT-1:0] O_STAT  = WIN_SHIFT'(OFF_STATUS);
  localparam logic [WIN_SHIFT-1:0] O_CLR   = WIN_SHIFT'(OFF_CLEAR);
  localparam logic [WIN_SHIFT-1:0] O_MASK  = WIN_SHIFT'(OFF_MASK);
  localparam logic [WIN_SHIFT-1:0] O_DOOR  = WIN_SHIFT'(OFF_DOOR);
  localparam logic [WIN_SHIFT-1:0] O_INFO0 = WIN_SHIFT'(OFF_INFO_BASE);
  localparam logic [WIN_SHIFT-1:0] O_INFON = WIN_SHIFT'(OFF_INFO_BASE + 4 * (INFO_WORDS - 1));

  logic [WIN_SHIFT-1:0] off;

  always_comb begin
    off          = addr_i[WIN_SHIFT-1:0];
    remote_o     = addr_i[AW-1];
    win_o        = addr_i[WIN_SHIFT +: WSELW];
    hit_o.status = (off == O_STAT);
    hit_o.clear  = (off == O_CLR);
    hit_o.mask   = (off == O_MASK);
    hit_o.door   = (off == O_DOOR);
    hit_o.info   = (off >= O_INFO0) && (off <= O_INFON) && (off[1:0] == 2'b00);
    idx_o        = IDXW'((off - O_INFO0) >> 2);
  end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DW         = 32,
  parameter int INFO_WORDS = 8,
  parameter int IDXW       = (INFO_WORDS > 1) ? $clog2(INFO_WORDS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             snd_we_i,
  input  logic [IDXW-1:0]                  snd_idx_i,
  input  logic [DW-1:0]                    snd_data_i,
  input  logic                             own_we_i,
  input  logic [IDXW-1:0]                  own_idx_i,
  input  logic [DW-1:0]                    own_data_i,
  output logic [INFO_WORDS-1:0][DW-1:0]    words_o
);

  logic [INFO_WORDS-1:0][DW-1:0] words_q, words_d;
  logic                          upd;

  always_comb begin
    upd     = snd_we_i | own_we_i;
    words_d = words_q;
    if (own_we_i) words_d[own_idx_i] = own_data_i;
    // sender write is applied last so it wins a same-word collision
    if (snd_we_i) words_d[snd_idx_i] = snd_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
    end else if (upd) begin
      words_q <= words_d;
    end
  end

  assign words_o = words_q;

endmodule

// File: rtl/mbx_intc.sv
module mbx_intc #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] set_i,
  input  logic [PW-1:0] clr_i,
  input  logic          mask_we_i,
  input  logic [PW-1:0] mask_wdata_i,
  output logic [PW-1:0] stat_o,
  output logic [PW-1:0] mask_o,
  output logic          irq_o
);

  logic [PW-1:0] stat_q, stat_d;
  logic [PW-1:0] mask_q;
  logic          irq_q, irq_d;

  always_comb begin
    // set term applied after clear: doorbell wins a collision
    stat_d = (stat_q & ~clr_i) | set_i;
    irq_d  = |(stat_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NPROC      = 4,
  parameter int DW         = 32,
  parameter int WIN_SHIFT  = 12,
  parameter int INFO_WORDS = 8,
  parameter int AW         = WIN_SHIFT + ((NPROC > 1) ? $clog2(NPROC) : 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPROC-1:0]    bus_valid,
  input  logic [NPROC-1:0]    bus_write,
  input  logic [NPROC*AW-1:0] bus_addr,
  input  logic [NPROC*DW-1:0] bus_wdata,
  output logic [NPROC*DW-1:0] bus_rdata,
  output logic [NPROC-1:0]    irq
);

  localparam int PW    = NPROC - 1;
  localparam int WSELW = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int IDXW  = (INFO_WORDS > 1) ? $clog2(INFO_WORDS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // per-port decode
  logic                 wr_v [NPROC];
  logic                 rd_v [NPROC];
  mbx_hit_t             hit  [NPROC];
  logic                 rem  [NPROC];
  logic [WSELW-1:0]     win  [NPROC];
  logic [IDXW-1:0]      idx  [NPROC];
  logic [DW-1:0]        wd   [NPROC];

  logic [INFO_WORDS-1:0][DW-1:0] mb_words [NPROC][NPROC];
  logic [PW-1:0]                 stat_vec [NPROC];
  logic [PW-1:0]                 mask_vec [NPROC];
  logic [NPROC*PW-1:0]           set_flat, clr_flat, stat_flat, mask_flat;

  for (genvar p = 0; p < NPROC; p++) begin : g_port
    assign wr_v[p] = bus_valid[p] & bus_write[p];
    assign rd_v[p] = bus_valid[p] & ~bus_write[p];
    assign wd[p]   = bus_wdata[p*DW +: DW];

    mbx_decode #(
      .NPROC(NPROC), .WIN_SHIFT(WIN_SHIFT), .INFO_WORDS(INFO_WORDS),
      .WSELW(WSELW), .IDXW(IDXW), .AW(AW)
    ) u_dec (
      .addr_i   (bus_addr[p*AW +: AW]),
      .hit_o    (hit[p]),
      .remote_o (rem[p]),
      .win_o    (win[p]),
      .idx_o    (idx[p])
    );

    logic [DW-1:0] rdat;
    always_comb begin
      rdat = '0;
      if (rd_v[p] && (win[p] != WSELW'(p))) begin
        if (hit[p].info) rdat = rem[p] ? mb_words[win[p]][p][idx[p]]
                                       : mb_words[p][win[p]][idx[p]];
      end
      if (rd_v[p] && !rem[p]) begin
        if (hit[p].status) rdat = DW'(stat_vec[p]);
        if (hit[p].mask)   rdat = DW'(mask_vec[p]);
      end
    end
    assign bus_rdata[p*DW +: DW] = rdat;
  end

  // information slots, one per ordered (receiver, sender) pair
  for (genvar r = 0; r < NPROC; r++) begin : g_rcv
    for (genvar s = 0; s < NPROC; s++) begin : g_snd
      if (r != s) begin : g_slot
        logic snd_we, own_we;
        assign snd_we = wr_v[s] & rem[s] & hit[s].info & (win[s] == WSELW'(r));
        assign own_we = wr_v[r] & ~rem[r] & hit[r].info & (win[r] == WSELW'(s));

        mbx_slot #(.DW(DW), .INFO_WORDS(INFO_WORDS), .IDXW(IDXW)) u_slot (
          .clk        (clk),
          .rst_n      (rst_sync_n),
          .snd_we_i   (snd_we),
          .snd_idx_i  (idx[s]),
          .snd_data_i (wd[s]),
          .own_we_i   (own_we),
          .own_idx_i  (idx[r]),
          .own_data_i (wd[r]),
          .words_o    (mb_words[r][s])
        );
      end else begin : g_self
        assign mb_words[r][s] = '0;
      end
    end

    // pending, clear and mask for receiver r
    logic [PW-1:0] ring_r, clr_r;
    logic          mask_we;

    always_comb begin
      ring_r = '0;
      for (int s = 0; s < NPROC; s++) begin
        if ((s != r) && wr_v[s] && rem[s] && hit[s].door && (win[s] == WSELW'(r)) &&
            (wd[s][DOOR_DATA_BIT] || wd[s][DOOR_ACK_BIT]))
          ring_r[peer_bit(r, s)] = 1'b1;
      end
      clr_r   = (wr_v[r] && !rem[r] && hit[r].clear) ? wd[r][PW-1:0] : '0;
      mask_we = wr_v[r] & ~rem[r] & hit[r].mask;
    end

    mbx_intc #(.PW(PW)) u_intc (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .set_i        (ring_r),
      .clr_i        (clr_r),
      .mask_we_i    (mask_we),
      .mask_wdata_i (wd[r][PW-1:0]),
      .stat_o       (stat_vec[r]),
      .mask_o       (mask_vec[r]),
      .irq_o        (irq[r])
    );

    assign set_flat[r*PW +: PW]  = ring_r;
    assign clr_flat[r*PW +: PW]  = clr_r;
    assign stat_flat[r*PW +: PW] = stat_vec[r];
    assign mask_flat[r*PW +: PW] = mask_vec[r];
  end

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
  parameter int NPROC = 4,
  parameter int PW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPROC*PW-1:0] set_flat,
  input logic [NPROC*PW-1:0] clr_flat,
  input logic [NPROC*PW-1:0] stat_flat,
  input logic [NPROC*PW-1:0] mask_flat,
  input logic [NPROC-1:0]    irq
);

  for (genvar r = 0; r < NPROC; r++) begin : g_r
    for (genvar b = 0; b < PW; b++) begin : g_b
      localparam int K = r * PW + b;

      AST_RING_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        set_flat[K] |=> stat_flat[K]);  // R4

      AST_CLEAR_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flat[K] && !set_flat[K]) |=> !stat_flat[K]);  // R5

      AST_RING_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flat[K] && set_flat[K]) |=> stat_flat[K]);  // R6

      AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_flat[K] && !set_flat[K]) |=> $stable(stat_flat[K]));  // R4
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flat[r*PW +: PW] == '0) |=> !irq[r]);  // R7

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq[r] |-> $past(stat_flat[r*PW +: PW] != '0));  // R7
  end

endmodule

bind mbx_bank mbx_bank_chk #(.NPROC(NPROC), .PW(PW)) u_mbx_bank_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .set_flat  (set_flat),
  .clr_flat  (clr_flat),
  .stat_flat (stat_flat),
  .mask_flat (mask_flat),
  .irq       (irq)
);

// File: tb/mbx_bank_bench.sv
`timescale 1ns/1ps
module mbx_bank_bench;

  localparam int NP = 4;
  localparam int AW = 15;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NP-1:0]    bus_valid;
  logic [NP-1:0]    bus_write;
  logic [NP*AW-1:0] bus_addr;
  logic [NP*DW-1:0] bus_wdata;
  logic [NP*DW-1:0] bus_rdata;
  logic [NP-1:0]    irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  mbx_bank u_mbx_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  port;
    logic        wr;
    logic [14:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 15'h4014, 32'hA1A1_0000, 4'd2},  // R2 P1 -> P0 word 0
    '{2'd0, 1'b0, 15'h1014, 32'hA1A1_0000, 4'd2},
    '{2'd1, 1'b1, 15'h4030, 32'h5A5A_0007, 4'd2},  // R2 ack word
    '{2'd0, 1'b0, 15'h1030, 32'h5A5A_0007, 4'd2},
    '{2'd2, 1'b1, 15'h402C, 32'h0000_0066, 4'd2},  // R2 word 6
    '{2'd0, 1'b0, 15'h202C, 32'h0000_0066, 4'd2},
    '{2'd0, 1'b0, 15'h102C, 32'h0000_0000, 4'd2},  // R2 slots independent
    '{2'd0, 1'b1, 15'h7020, 32'h0000_0033, 4'd1},  // R1 P0 -> P3 word 3
    '{2'd3, 1'b0, 15'h0020, 32'h0000_0033, 4'd1},
    '{2'd0, 1'b0, 15'h7020, 32'h0000_0033, 4'd2},  // R2 remote read
    '{2'd0, 1'b1, 15'h0014, 32'h0000_0099, 4'd8},  // R8 own window
    '{2'd0, 1'b0, 15'h0014, 32'h0000_0000, 4'd8},
    '{2'd0, 1'b1, 15'h0008, 32'hFFFF_FFFF, 4'd8},  // R8 unused offset
    '{2'd0, 1'b0, 15'h0008, 32'h0000_0000, 4'd8},
    '{2'd0, 1'b1, 15'h000C, 32'h0000_0005, 4'd7},  // R7 mask
    '{2'd0, 1'b0, 15'h000C, 32'h0000_0005, 4'd7},
    '{2'd0, 1'b0, 15'h0010, 32'h0000_0000, 4'd8},  // R8 doorbell reads 0
    '{2'd3, 1'b1, 15'h4010, 32'h0000_0040, 4'd3},  // R3 P3 rings P0
    '{2'd0, 1'b0, 15'h0000, 32'h0000_0004, 4'd3},
    '{2'd1, 1'b1, 15'h4010, 32'h0000_0080, 4'd4},  // R4 ack bit
    '{2'd0, 1'b0, 15'h0000, 32'h0000_0005, 4'd4},
    '{2'd2, 1'b1, 15'h4010, 32'h0000_003F, 4'd4},  // R4 other bits
    '{2'd0, 1'b0, 15'h1000, 32'h0000_0005, 4'd4},
    '{2'd0, 1'b1, 15'h0004, 32'h0000_0001, 4'd5},  // R5 clear one
    '{2'd0, 1'b0, 15'h0000, 32'h0000_0004, 4'd5},
    '{2'd0, 1'b1, 15'h0004, 32'h0000_00FF, 4'd5},  // R5 clear all
    '{2'd0, 1'b0, 15'h0000, 32'h0000_0000, 4'd5},
    '{2'd0, 1'b1, 15'h6010, 32'h0000_0040, 4'd3},  // R3 P0 rings P2
    '{2'd3, 1'b1, 15'h6010, 32'h0000_0080, 4'd3},  // R3 P3 rings P2
    '{2'd2, 1'b0, 15'h0000, 32'h0000_0005, 4'd3},
    '{2'd2, 1'b1, 15'h0004, 32'h0000_00FF, 4'd5}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_port(input int p, input logic wr, input logic [14:0] a, input logic [31:0] d);
    bus_valid[p]         = 1'b1;
    bus_write[p]         = wr;
    bus_addr[p*AW +: AW] = a;
    bus_wdata[p*DW +: DW] = d;
  endtask

  task automatic idle();
    bus_valid = '0;
    bus_write = '0;
    bus_addr  = '0;
    bus_wdata = '0;
  endtask

  task automatic wr1(input int p, input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    set_port(p, 1'b1, a, d);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input int p, input logic [14:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    set_port(p, 1'b0, a, 32'h0);
    #1;
    check(tag, bus_rdata[p*DW +: DW], exp);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    do_reset();

    // R9 reset state
    check("R9 irq after reset", 32'(irq), 32'h0);
    rd_chk(0, 15'h0000, 32'h0, "R9 status");
    rd_chk(0, 15'h000C, 32'h0, "R9 mask");
    rd_chk(0, 15'h1014, 32'h0, "R9 info");

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        wr1(int'(VECS[i].port), VECS[i].addr, VECS[i].data);
      end else begin
        rd_chk(int'(VECS[i].port), VECS[i].addr, VECS[i].data,
               $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end

    // R7 interrupt timing: mask for P0 is 0x5, status is 0
    check("R7 irq idle", 32'(irq[0]), 32'h0);
    wr1(1, 15'h4010, 32'h40);
    check("R7 irq one cycle late", 32'(irq[0]), 32'h0);
    @(negedge clk);
    check("R7 irq raised", 32'(irq[0]), 32'h1);
    wr1(0, 15'h0004, 32'h1);
    check("R7 irq still high", 32'(irq[0]), 32'h1);
    @(negedge clk);
    check("R7 irq dropped", 32'(irq[0]), 32'h0);

    // R7 masked source stays quiet
    wr1(0, 15'h000C, 32'h4);
    wr1(1, 15'h4010, 32'h40);
    @(negedge clk);
    check("R7 masked irq", 32'(irq[0]), 32'h0);
    rd_chk(0, 15'h0000, 32'h1, "R7 masked status");
    wr1(0, 15'h0004, 32'hFF);

    // R6 doorbell beats clear in the same cycle
    wr1(3, 15'h4010, 32'h40);
    @(negedge clk);
    set_port(1, 1'b1, 15'h4010, 32'h40);
    set_port(0, 1'b1, 15'h0004, 32'h5);
    @(negedge clk);
    idle();
    rd_chk(0, 15'h0000, 32'h1, "R6 ring beats clear");

    // R10 sender write wins over owner write to the same word
    @(negedge clk);
    set_port(1, 1'b1, 15'h401C, 32'hBBBB_0002);
    set_port(0, 1'b1, 15'h101C, 32'hCCCC_0002);
    @(negedge clk);
    idle();
    rd_chk(0, 15'h101C, 32'hBBBB_0002, "R10 sender wins");

    // R2 owner clears its own word
    wr1(0, 15'h1014, 32'h0);
    rd_chk(1, 15'h4014, 32'h0, "R2 owner write");

    // R9 reset mid-run
    do_reset();
    check("R9 irq after second reset", 32'(irq), 32'h0);
    rd_chk(0, 15'h0000, 32'h0, "R9 status cleared");
    rd_chk(0, 15'h000C, 32'h0, "R9 mask cleared");
    rd_chk(0, 15'h101C, 32'h0, "R9 info cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule